// File: doc/BRIEF.md
# Byte-wide host to 16-bit ATA bridge

This block sits between an 8-bit host I/O bus and an ATA/IDE device that moves data sixteen bits at a time. It decodes a ten-port window at offsets 6 to 15 above a parameterised base address. Every port except the data port is passed straight through: one host access becomes one device register cycle on the command block (offsets 9 to 15) or the control block (offsets 6 and 7).

The data port at offset 8 is handled differently. It is backed by a one-word holding buffer, so the host moves each 16-bit device word as two byte accesses, low byte first. A byte-phase toggle tracks which half comes next. Reset clears the toggle, and so does any access to a non-data register, which puts the pairing back in step after a lost byte.

Each device cycle is run by a three-state machine: `ST_IDLE`, `ST_SETUP` and `ST_STROBE`.
- `ST_IDLE` to `ST_SETUP`: an accepted access that needs the device.
- `ST_SETUP` to `ST_STROBE`: always, after one clock.
- `ST_STROBE` to `ST_IDLE`: once the strobe has been held for `STROBE_CYC` clocks and the device reports ready.

While the machine is out of `ST_IDLE`, the host sees its wait output asserted.

Top module: `bytewide_ata_bridge`

## Requirements
- R1: After reset, h_wait is 0, ata_cs_n is 2'b11, ata_rd_n and ata_wr_n are 1, ata_dd_oe is 0 and h_rdata is 8'h00.
- R2: A host access to offsets 9 to 15 runs one device cycle with ata_cs_n = 2'b10 (bit 0 low, command block) and ata_da = offset[2:0]. A read returns the low byte of ata_dd_in on h_rdata.
- R3: A read of offset 6 or 7, or a write of offset 6, runs one device cycle with ata_cs_n = 2'b01 (bit 1 low, control block) and ata_da = 6 or 7.
- R4: A write to offset 7 starts no device cycle and leaves h_wait low.
- R5: An access outside offsets 6 to 15 starts no device cycle and leaves h_rdata and the byte phase unchanged.
- R6: An accepted device access raises h_wait on the next clock. Chip select and address are presented for one clock with no strobe. The strobe is then held for STROBE_CYC clocks, and h_wait is high for STROBE_CYC+1 clocks in total.
- R7: While ata_rdy is 0 at the last strobe clock, the strobe and h_wait are extended until ata_rdy is 1.
- R8: The first data-port read starts a 16-bit device read and returns bits 7:0 of the word. The second returns bits 15:8 of the same word and starts no device cycle.
- R9: The first data-port write is held with no device cycle. The second starts one device write of {second byte, first byte}, with ata_dd_oe high for the whole cycle.
- R10: Any access to a non-data register clears the byte phase, so the next data-port access is treated as a first byte.
- R11: A register write drives ata_dd_out = {8'h00, host byte} during its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_addr | input | AW | Host I/O address |
| h_wdata | input | 8 | Host write byte |
| h_rd | input | 1 | Host read strobe, one clock, taken when h_wait is low |
| h_wr | input | 1 | Host write strobe, one clock, taken when h_wait is low |
| h_rdata | output | 8 | Host read byte, valid once h_wait is low |
| h_wait | output | 1 | Host stall while a device cycle runs |
| ata_cs_n | output | 2 | Chip selects, active low: bit 0 command block, bit 1 control block |
| ata_da | output | 3 | Device register address |
| ata_dd_out | output | 16 | Device data bus, outgoing |
| ata_dd_oe | output | 1 | Device data bus drive enable |
| ata_dd_in | input | 16 | Device data bus, incoming |
| ata_rd_n | output | 1 | Device read strobe, active low |
| ata_wr_n | output | 1 | Device write strobe, active low |
| ata_rdy | input | 1 | Device ready, high when the cycle may end |

## Verification
A host strobe is taken at one clock edge, and h_wait, chip select and address change at that same edge. The strobe follows one clock later. Read data and the high-byte latch are loaded at the edge that ends the strobe, which is STROBE_CYC+1 edges after acceptance, or later under a ready stall. The second data-port read returns its byte at the edge that accepts it. The bench model advances at each rising edge from the same inputs, and every output is compared at the following falling edge, where all of these results have already settled. Stimulus changes just after that falling edge.

// File: rtl/atab_pkg.sv
package atab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE
    } cyc_state_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_DATA,
        ACC_REG
    } acc_kind_t;

    typedef enum logic {
        BLK_CMD  = 1'b0,
        BLK_CTRL = 1'b1
    } blk_t;

    typedef struct packed {
        acc_kind_t  kind;
        blk_t       blk;
        logic [2:0] reg_a;
    } port_dec_t;

    localparam int NUM_CS = 2;

endpackage

// File: rtl/atab_port_decode.sv
module atab_port_decode
    import atab_pkg::*;
#(
    parameter int             AW        = 16,
    parameter logic [AW-1:0]  PORT_BASE = 16'hFD00
) (
    input  logic [AW-1:0] addr,
    input  logic          is_wr,
    output port_dec_t     dec
);
    localparam logic [3:0] OFF_FIRST = 4'd6;
    localparam logic [3:0] OFF_DATA  = 4'd8;
    localparam logic [3:0] OFF_DRVAD = 4'd7;

    logic in_win;

    always_comb begin
        in_win    = (addr[AW-1:4] == PORT_BASE[AW-1:4]) && (addr[3:0] >= OFF_FIRST);
        dec.reg_a = addr[2:0];
        dec.blk   = addr[3] ? BLK_CMD : BLK_CTRL;
        if (!in_win) begin
            dec.kind = ACC_NONE;
        end else if (addr[3:0] == OFF_DATA) begin
            dec.kind = ACC_DATA;
        end else if (addr[3:0] == OFF_DRVAD && is_wr) begin
            dec.kind = ACC_NONE;
        end else begin
            dec.kind = ACC_REG;
        end
    end
endmodule

// File: rtl/atab_word_buf.sv
module atab_word_buf (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_phase,
    input  logic       clr_phase,
    input  logic       lo_we,
    input  logic [7:0] lo_d,
    input  logic       hi_we,
    input  logic [7:0] hi_d,
    output logic       phase,
    output logic [7:0] lo_q,
    output logic [7:0] hi_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= 1'b0;
            lo_q  <= 8'h00;
            hi_q  <= 8'h00;
        end else begin
            if (clr_phase) begin
                phase <= 1'b0;
            end else if (set_phase) begin
                phase <= 1'b1;
            end
            if (lo_we) begin
                lo_q <= lo_d;
            end
            if (hi_we) begin
                hi_q <= hi_d;
            end
        end
    end
endmodule

// File: rtl/atab_cycle_fsm.sv
module atab_cycle_fsm
    import atab_pkg::*;
#(
    parameter int STROBE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_rd,
    input  logic ata_rdy,
    output logic busy,
    output logic dir_rd,
    output logic strobe_rd,
    output logic strobe_wr,
    output logic cap
);
    localparam int CW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
    localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

    cyc_state_t    state, nstate;
    logic [CW-1:0] cnt;
    logic          last_ok;

    assign last_ok = (cnt == LAST) && ata_rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_rd <= 1'b0;
        end else begin
            if (state == ST_IDLE && start) begin
                dir_rd <= start_rd;
            end
            if (state == ST_SETUP) begin
                cnt <= '0;
            end else if (state == ST_STROBE && cnt != LAST) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (start)   nstate = ST_SETUP;
            ST_SETUP:               nstate = ST_STROBE;
            ST_STROBE: if (last_ok) nstate = ST_IDLE;
            default:                nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        strobe_rd = 1'b0;
        strobe_wr = 1'b0;
        cap       = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SETUP: busy = 1'b1;
            ST_STROBE: begin
                busy      = 1'b1;
                strobe_rd = dir_rd;
                strobe_wr = !dir_rd;
                cap       = dir_rd && last_ok;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bytewide_ata_bridge.sv
module bytewide_ata_bridge
    import atab_pkg::*;
#(
    parameter int            AW         = 16,
    parameter logic [AW-1:0] PORT_BASE  = 16'hFD00,
    parameter int            STROBE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_wdata,
    input  logic          h_rd,
    input  logic          h_wr,
    output logic [7:0]    h_rdata,
    output logic          h_wait,
    output logic [1:0]    ata_cs_n,
    output logic [2:0]    ata_da,
    output logic [15:0]   ata_dd_out,
    output logic          ata_dd_oe,
    input  logic [15:0]   ata_dd_in,
    output logic          ata_rd_n,
    output logic          ata_wr_n,
    input  logic          ata_rdy
);
    port_dec_t  dec;
    logic       is_rd, is_wr, acc;
    logic       busy, dir_rd, strobe_rd, strobe_wr, cap;
    logic       start;
    logic       phase;
    logic [7:0] lo_q, hi_q;
    logic       set_phase, clr_phase, lo_we, hi_rd;
    logic       acc_data, acc_reg;
    blk_t       blk_q;
    logic [2:0] reg_q;
    logic [15:0] dout_q;
    logic       data_q;

    assign is_rd = h_rd;
    assign is_wr = h_wr && !h_rd;

    atab_port_decode #(.AW(AW), .PORT_BASE(PORT_BASE)) u_dec (
        .addr  (h_addr),
        .is_wr (is_wr),
        .dec   (dec)
    );

    always_comb begin
        acc       = (h_rd || h_wr) && !busy;
        acc_data  = acc && (dec.kind == ACC_DATA);
        acc_reg   = acc && (dec.kind == ACC_REG);
        lo_we     = acc_data && is_wr && !phase;
        hi_rd     = acc_data && is_rd && phase;
        set_phase = acc_data && !phase;
        clr_phase = acc_reg || (acc_data && phase);
        start     = acc_reg || (acc_data && (is_rd ? !phase : phase));
    end

    atab_word_buf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_phase (set_phase),
        .clr_phase (clr_phase),
        .lo_we     (lo_we),
        .lo_d      (h_wdata),
        .hi_we     (cap && data_q),
        .hi_d      (ata_dd_in[15:8]),
        .phase     (phase),
        .lo_q      (lo_q),
        .hi_q      (hi_q)
    );

    atab_cycle_fsm #(.STROBE_CYC(STROBE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_rd  (is_rd),
        .ata_rdy   (ata_rdy),
        .busy      (busy),
        .dir_rd    (dir_rd),
        .strobe_rd (strobe_rd),
        .strobe_wr (strobe_wr),
        .cap       (cap)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= BLK_CMD;
            reg_q  <= 3'd0;
            dout_q <= 16'h0000;
            data_q <= 1'b0;
        end else if (start) begin
            blk_q  <= dec.blk;
            reg_q  <= dec.reg_a;
            data_q <= (dec.kind == ACC_DATA);
            dout_q <= (dec.kind == ACC_DATA) ? {h_wdata, lo_q} : {8'h00, h_wdata};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_rdata <= 8'h00;
        end else if (cap) begin
            h_rdata <= ata_dd_in[7:0];
        end else if (hi_rd) begin
            h_rdata <= hi_q;
        end
    end

    for (genvar b = 0; b < NUM_CS; b++) begin : g_cs
        assign ata_cs_n[b] = !(busy && (logic'(blk_q) == 1'(b)));
    end

    assign h_wait     = busy;
    assign ata_da     = busy ? reg_q : 3'd0;
    assign ata_dd_out = dout_q;
    assign ata_dd_oe  = busy && !dir_rd;
    assign ata_rd_n   = !strobe_rd;
    assign ata_wr_n   = !strobe_wr;
endmodule

// File: rtl/atab_checker.sv
module atab_checker #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] PORT_BASE = 16'hFD00
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] h_addr,
    input logic          h_rd,
    input logic          h_wr,
    input logic          h_wait,
    input logic [1:0]    ata_cs_n,
    input logic [2:0]    ata_da,
    input logic          ata_dd_oe,
    input logic          ata_rd_n,
    input logic          ata_wr_n
);
    localparam logic [AW-1:0] ADDR_DRVAD = PORT_BASE | AW'(7);

    logic in_win;
    assign in_win = (h_addr[AW-1:4] == PORT_BASE[AW-1:4]) && (h_addr[3:0] >= 4'd6);

    a_r4_drvad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && !h_rd && !h_wait && h_addr == ADDR_DRVAD) |=> (!h_wait && ata_wr_n));

    a_r5_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        ((h_rd || h_wr) && !h_wait && !in_win) |=> (!h_wait && ata_rd_n && ata_wr_n));

    a_r6_strobe_stalls_host: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n) |-> h_wait);

    a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n) |-> ($countones(~ata_cs_n) == 1));

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wait && $past(h_wait)) |-> ($stable(ata_cs_n) && $stable(ata_da)));

    a_r9_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_wr_n |-> ata_dd_oe);
endmodule

bind bytewide_ata_bridge atab_checker #(.AW(AW), .PORT_BASE(PORT_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_addr    (h_addr),
    .h_rd      (h_rd),
    .h_wr      (h_wr),
    .h_wait    (h_wait),
    .ata_cs_n  (ata_cs_n),
    .ata_da    (ata_da),
    .ata_dd_oe (ata_dd_oe),
    .ata_rd_n  (ata_rd_n),
    .ata_wr_n  (ata_wr_n)
);

// File: tb/sim_bytewide_ata_bridge.sv
`timescale 1ns/1ps
module sim_bytewide_ata_bridge;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_addr = 16'h0000;
    logic [7:0]  h_wdata = 8'h00;
    logic        h_rd = 1'b0;
    logic        h_wr = 1'b0;
    logic [7:0]  h_rdata;
    logic        h_wait;
    logic [1:0]  ata_cs_n;
    logic [2:0]  ata_da;
    logic [15:0] ata_dd_out;
    logic        ata_dd_oe;
    logic [15:0] ata_dd_in = 16'h0000;
    logic        ata_rd_n;
    logic        ata_wr_n;
    logic        ata_rdy = 1'b1;

    bytewide_ata_bridge #(.AW(16), .PORT_BASE(16'hFD00), .STROBE_CYC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rd(h_rd), .h_wr(h_wr), .h_rdata(h_rdata), .h_wait(h_wait),
        .ata_cs_n(ata_cs_n), .ata_da(ata_da), .ata_dd_out(ata_dd_out),
        .ata_dd_oe(ata_dd_oe), .ata_dd_in(ata_dd_in), .ata_rd_n(ata_rd_n),
        .ata_wr_n(ata_wr_n), .ata_rdy(ata_rdy)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    // behavioural reference model
    bit        m_busy = 0, m_setup = 0, m_rd = 0, m_data = 0, m_phase = 0;
    int        m_cnt = 0, m_blk = 0, m_da = 0;
    bit [15:0] m_dout = 0;
    bit [7:0]  m_lo = 0, m_hi = 0, m_rdata = 0;

    task automatic m_start(input bit rd, input int off, input bit data, input bit [15:0] w);
        m_busy = 1; m_setup = 1; m_rd = rd; m_data = data;
        m_blk = (off >= 8) ? 0 : 1;
        m_da = off % 8;
        m_dout = w;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_setup = 0; m_phase = 0; m_lo = 0; m_hi = 0; m_rdata = 0;
        end else if (m_busy) begin
            if (m_setup) begin
                m_setup = 0; m_cnt = 0;
            end else if (m_cnt == N - 1) begin
                if (ata_rdy) begin
                    if (m_rd) begin
                        m_rdata = ata_dd_in[7:0];
                        if (m_data) m_hi = ata_dd_in[15:8];
                    end
                    m_busy = 0;
                end
            end else begin
                m_cnt++;
            end
        end else if (h_rd || h_wr) begin
            int off;
            bit rd;
            rd = h_rd;
            off = int'(h_addr) - 32'hFD00;
            if (off >= 6 && off <= 15) begin
                if (off == 8) begin
                    if (rd) begin
                        if (!m_phase) begin m_start(1, off, 1, 16'h0); m_phase = 1; end
                        else begin m_rdata = m_hi; m_phase = 0; end
                    end else begin
                        if (!m_phase) begin m_lo = h_wdata; m_phase = 1; end
                        else begin m_start(0, off, 1, {h_wdata, m_lo}); m_phase = 0; end
                    end
                end else if (!(!rd && off == 7)) begin
                    m_start(rd, off, 0, {8'h00, h_wdata});
                    m_phase = 0;
                end
            end
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // per-cycle comparison and bus monitors
    int        wait_run = 0, last_wait_len = 0, strobe_cycles = 0;
    bit [15:0] last_wr_word = 0;
    int        last_wr_da = 0;
    always @(negedge clk) begin
        bit strobe;
        strobe = m_busy && !m_setup;
        cmp("h_wait",   h_wait, m_busy);
        cmp("h_rdata",  h_rdata, m_rdata);
        cmp("ata_cs_n", ata_cs_n, m_busy ? (m_blk == 0 ? 2 : 1) : 3);
        cmp("ata_rd_n", ata_rd_n, !(strobe && m_rd));
        cmp("ata_wr_n", ata_wr_n, !(strobe && !m_rd));
        cmp("ata_dd_oe", ata_dd_oe, m_busy && !m_rd);
        if (m_busy) cmp("ata_da", ata_da, m_da);
        if (m_busy && !m_rd) cmp("ata_dd_out", ata_dd_out, m_dout);
        if (h_wait) wait_run++;
        else if (wait_run > 0) begin last_wait_len = wait_run; wait_run = 0; end
        if (!ata_rd_n || !ata_wr_n) strobe_cycles++;
        if (!ata_wr_n) begin last_wr_word = ata_dd_out; last_wr_da = ata_da; end
    end

    task automatic host_op(input bit rd, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); #1;
        h_addr = a; h_wdata = d; h_rd = rd; h_wr = !rd;
        @(negedge clk); #1;
        h_rd = 0; h_wr = 0;
        while (h_wait) begin @(negedge clk); #1; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int sc;
        repeat (4) @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        cmp("reset h_wait", h_wait, 0);
        cmp("reset cs_n", ata_cs_n, 3);
        cmp("reset oe", ata_dd_oe, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 and R11 command-block registers
        cur_req = "R11";
        host_op(0, 16'hFD0A, 8'h12);
        cmp("reg write word", last_wr_word, 16'h0012);
        cmp("reg write addr", last_wr_da, 2);
        cur_req = "R2";
        ata_dd_in = 16'h3C58;
        host_op(1, 16'hFD0F, 8'h00);
        cmp("status read", h_rdata, 8'h58);
        host_op(0, 16'hFD0F, 8'hEC);
        cmp("command write addr", last_wr_da, 7);
        ata_dd_in = 16'h0041;
        host_op(1, 16'hFD09, 8'h00);
        cmp("error read", h_rdata, 8'h41);

        // R6 wait length
        cur_req = "R6";
        cmp("wait length", last_wait_len, N + 1);

        // R3 control block
        cur_req = "R3";
        ata_dd_in = 16'h00A6;
        host_op(1, 16'hFD06, 8'h00);
        cmp("alt status read", h_rdata, 8'hA6);
        ata_dd_in = 16'h00C7;
        host_op(1, 16'hFD07, 8'h00);
        cmp("drive address read", h_rdata, 8'hC7);
        host_op(0, 16'hFD06, 8'h04);
        cmp("device control write addr", last_wr_da, 6);

        // R4 write to drive address port ignored
        cur_req = "R4";
        sc = strobe_cycles;
        host_op(0, 16'hFD07, 8'h55);
        @(negedge clk);
        cmp("no cycle on write 7", strobe_cycles, sc);
        cmp("rdata kept", h_rdata, 8'hC7);

        // R5 out-of-window accesses ignored, phase kept
        cur_req = "R5";
        host_op(0, 16'hFD08, 8'h34);
        sc = strobe_cycles;
        host_op(1, 16'hFD05, 8'h00);
        host_op(0, 16'hFC08, 8'h99);
        host_op(1, 16'hFD18, 8'h00);
        @(negedge clk);
        cmp("no cycle outside", strobe_cycles, sc);
        cmp("rdata unchanged", h_rdata, 8'hC7);
        // R9 second data byte completes the word
        cur_req = "R9";
        host_op(0, 16'hFD08, 8'h12);
        cmp("data word", last_wr_word, 16'h1234);
        cmp("data strobe count", strobe_cycles - sc, N);

        // R8 data read pair
        cur_req = "R8";
        ata_dd_in = 16'hBEEF;
        host_op(1, 16'hFD08, 8'h00);
        cmp("data low byte", h_rdata, 8'hEF);
        ata_dd_in = 16'h0000;
        sc = strobe_cycles;
        host_op(1, 16'hFD08, 8'h00);
        @(negedge clk);
        cmp("data high byte", h_rdata, 8'hBE);
        cmp("no cycle on high read", strobe_cycles, sc);

        // R10 register access realigns phase
        cur_req = "R10";
        host_op(0, 16'hFD08, 8'hAA);
        host_op(0, 16'hFD0B, 8'h01);
        host_op(0, 16'hFD08, 8'h11);
        host_op(0, 16'hFD08, 8'h22);
        cmp("realigned word", last_wr_word, 16'h2211);
        ata_dd_in = 16'h7766;
        host_op(1, 16'hFD08, 8'h00);
        host_op(1, 16'hFD0C, 8'h00);
        ata_dd_in = 16'h5544;
        host_op(1, 16'hFD08, 8'h00);
        cmp("read restarts at low", h_rdata, 8'h44);
        host_op(1, 16'hFD08, 8'h00);

        // R7 ready stall extends the cycle
        cur_req = "R7";
        ata_rdy = 1'b0;
        ata_dd_in = 16'h00D5;
        @(negedge clk); #1;
        h_addr = 16'hFD0D; h_rd = 1;
        @(negedge clk); #1;
        h_rd = 0;
        repeat (8) @(negedge clk);
        #1 ata_rdy = 1'b1;
        while (h_wait) begin @(negedge clk); #1; end
        cmp("stalled read data", h_rdata, 8'hD5);
        cmp("stall lengthens wait", int'(last_wait_len > N + 1), 1);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule